// File: doc/BRIEF.md
# Ring Buffer Burst Wrap Splitter

This block turns one request to move a run of 16-byte quadwords into one or two bursts on a request channel. The source pointer (`madr_i`) may sit inside a power-of-two ring described by a base address and a mask, or anywhere outside it. Inside the ring, the run is capped by whichever is smaller: the channel's remaining count or the number of quadwords a producer has made available. If the capped run would pass the ring's last quadword, the block issues the part up to the ring end first. It then issues the rest starting again at the base. Outside the ring, the block issues a single linear burst of the full channel count.

The block is started by a single-cycle `start_i` pulse. It samples all configuration inputs on that edge. It then drives bursts on a valid/ready request channel. A request stays valid, with its address and length held stable, until `req_ready_i` is seen high. Only one burst is outstanding at a time. After each accepted request, the block raises `rsp_ready_o` and waits for `rsp_valid_i`, which carries the number of quadwords the data path actually moved. That count must not exceed the requested length.

When the last response arrives, `done_o` pulses for one cycle. The updated pointer, the updated available count, the total moved and a cycle cost are then presented, and they hold until the next start. The data path itself is outside this block.

Top module: `ring_wrap_splitter`

## Requirements
- R1: For a pointer inside the ring, the run length is min(`avail_i`, `qwc_i`). For a pointer outside the ring, the run length is `qwc_i`. A run length of zero issues no request, pulses `done_o` one cycle after the start, and reports pointer and available count unchanged, with moved and cost zero.
- R2: Inside the ring, a wrap happens when `madr_i` + len*16 > base + mask + 16 (a run ending exactly at base + mask + 16 does not wrap). On a wrap, the first burst is at `madr_i` with length (base + mask + 16 − `madr_i`) >> 4. The second burst is at the base with the remaining quadwords. No burst inside the ring crosses the ring end.
- R3: On a wrap, if the first response count is below the first burst length, the second burst is skipped and the moved total equals that count.
- R4: Inside the ring without a wrap, exactly one burst of the full length is issued at `madr_i`. After it, `madr_o` = base + (`madr_i` AND mask).
- R5: Inside the ring, `avail_o` = `avail_i` minus the total quadwords reported moved. `moved_o` is the sum of the response counts.
- R6: The pointer is inside the ring when base ≤ `madr_i` ≤ base + mask. Otherwise one linear burst of `qwc_i` at `madr_i` is issued. `madr_o` and `avail_o` are then unchanged, and `cost_o` = 2 × moved. Inside the ring, `cost_o` is 0.
- R7: While `req_valid_o` is high and `req_ready_i` is low, the request address and length stay stable. The request channel and the response acceptance (`rsp_ready_o`) are never active in the same cycle, and every request carries a nonzero length.
- R8: `busy_o` is high from the cycle after an accepted start through the `done_o` cycle. `done_o` lasts exactly one cycle. A start pulse or input change while busy has no effect on the bursts or results.
- R9: After a wrap, `madr_o` equals the `madr_i` sampled at the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, accepted only while idle |
| ring_base_i | input | AW | Ring base byte address |
| ring_mask_i | input | AW | Ring mask, of the form 2^k*16 − 16 |
| madr_i | input | AW | Source pointer (byte address, quadword aligned) |
| qwc_i | input | CW | Channel remaining quadword count |
| avail_i | input | CW | Quadwords made available by the producer |
| req_valid_o | output | 1 | Burst request valid |
| req_ready_i | input | 1 | Burst request accepted |
| req_addr_o | output | AW | Burst start address |
| req_len_o | output | CW | Burst length in quadwords |
| rsp_valid_i | input | 1 | Burst completion valid |
| rsp_ready_o | output | 1 | Block waits for a completion |
| rsp_cnt_i | input | CW | Quadwords actually moved by the burst |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| madr_o | output | AW | Updated pointer |
| avail_o | output | CW | Updated available count |
| moved_o | output | CW | Total quadwords moved |
| cost_o | output | CW+1 | Cycle cost of a linear burst |

## Verification
On every cycle, the assertions check the request hold rule, the exclusion between request and response phases, and nonzero burst lengths. They also check that no ring burst reaches past the ring end, that the done pulse lasts one cycle, and that the moved total never exceeds what was requested. The exact split point, the skipping of the second burst after a short first completion, the pointer normalisation, the linear cost and the avail arithmetic need concrete operands. The bench's reference model covers these with scenarios at the ring edges, with capped and zero runs, and with start pulses injected while busy.

// File: rtl/ring_pkg.sv
package ring_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ1,
    ST_RSP1,
    ST_REQ2,
    ST_RSP2,
    ST_DONE
  } seq_state_e;
endpackage

// File: rtl/ring_plan.sv
module ring_plan #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] mask_i,
  input  logic [AW-1:0] madr_i,
  input  logic [CW-1:0] qwc_i,
  input  logic [CW-1:0] avail_i,
  output logic          in_ring_o,
  output logic          wrap_o,
  output logic [CW-1:0] len_o,
  output logic [CW-1:0] first_len_o,
  output logic [CW-1:0] second_len_o
);
  localparam int XW = AW + CW + 5;

  logic [XW-1:0] base_x, top_x, end_x, madr_x, reach_x, span_x;
  logic [CW-1:0] capped;

  always_comb begin
    base_x    = XW'(base_i);
    top_x     = base_x + XW'(mask_i);
    end_x     = top_x + XW'(16);
    madr_x    = XW'(madr_i);
    in_ring_o = (madr_x >= base_x) && (madr_x <= top_x);
    capped    = (avail_i < qwc_i) ? avail_i : qwc_i;
    len_o     = in_ring_o ? capped : qwc_i;
    reach_x   = madr_x + (XW'(len_o) << 4);
    wrap_o    = in_ring_o && (reach_x > end_x);
    span_x    = (end_x - madr_x) >> 4;
    first_len_o  = wrap_o ? CW'(span_x) : len_o;
    second_len_o = wrap_o ? (len_o - CW'(span_x)) : '0;
  end
endmodule

// File: rtl/ring_seq.sv
module ring_seq import ring_pkg::*; #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          in_ring_i,
  input  logic          wrap_i,
  input  logic [CW-1:0] len_i,
  input  logic [CW-1:0] first_len_i,
  input  logic [CW-1:0] second_len_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] mask_i,
  input  logic [AW-1:0] madr_i,
  input  logic [CW-1:0] avail_i,
  output logic          req_valid_o,
  input  logic          req_ready_i,
  output logic [AW-1:0] req_addr_o,
  output logic [CW-1:0] req_len_o,
  input  logic          rsp_valid_i,
  output logic          rsp_ready_o,
  input  logic [CW-1:0] rsp_cnt_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [AW-1:0] madr_o,
  output logic [CW-1:0] avail_o,
  output logic [CW-1:0] moved_o,
  output logic [CW:0]   cost_o
);
  localparam int XW = AW + CW + 5;

  seq_state_e    st_q, st_d;
  logic          lin_q, wrap_q;
  logic [CW-1:0] first_q, second_q, part_q, avail_q;
  logic [AW-1:0] base_q, mask_q, madr_q;
  logic [AW-1:0] madr_r;
  logic [CW-1:0] avail_r, moved_r;
  logic [CW:0]   cost_r;
  logic          fin;
  logic [CW-1:0] fin_total;

  always_comb begin
    st_d      = st_q;
    fin       = 1'b0;
    fin_total = '0;
    case (st_q)
      ST_IDLE: if (start_i) st_d = (len_i == '0) ? ST_DONE : ST_REQ1;
      ST_REQ1: if (req_ready_i) st_d = ST_RSP1;
      ST_RSP1: if (rsp_valid_i) begin
        if (wrap_q && (rsp_cnt_i == first_q)) st_d = ST_REQ2;
        else begin
          st_d      = ST_DONE;
          fin       = 1'b1;
          fin_total = rsp_cnt_i;
        end
      end
      ST_REQ2: if (req_ready_i) st_d = ST_RSP2;
      ST_RSP2: if (rsp_valid_i) begin
        st_d      = ST_DONE;
        fin       = 1'b1;
        fin_total = part_q + rsp_cnt_i;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      lin_q    <= 1'b0;
      wrap_q   <= 1'b0;
      first_q  <= '0;
      second_q <= '0;
      part_q   <= '0;
      avail_q  <= '0;
      base_q   <= '0;
      mask_q   <= '0;
      madr_q   <= '0;
      madr_r   <= '0;
      avail_r  <= '0;
      moved_r  <= '0;
      cost_r   <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && start_i) begin
        lin_q    <= !in_ring_i;
        wrap_q   <= wrap_i;
        first_q  <= first_len_i;
        second_q <= second_len_i;
        avail_q  <= avail_i;
        base_q   <= base_i;
        mask_q   <= mask_i;
        madr_q   <= madr_i;
        if (len_i == '0) begin
          madr_r  <= madr_i;
          avail_r <= avail_i;
          moved_r <= '0;
          cost_r  <= '0;
        end
      end
      if (st_q == ST_RSP1 && rsp_valid_i) part_q <= rsp_cnt_i;
      if (fin) begin
        moved_r <= fin_total;
        if (lin_q) begin
          madr_r  <= madr_q;
          avail_r <= avail_q;
          cost_r  <= {fin_total, 1'b0};
        end else begin
          madr_r  <= wrap_q ? madr_q : (base_q + (madr_q & mask_q));
          avail_r <= avail_q - fin_total;
          cost_r  <= '0;
        end
      end
    end
  end

  assign req_valid_o = (st_q == ST_REQ1) || (st_q == ST_REQ2);
  assign req_addr_o  = (st_q == ST_REQ2) ? base_q : madr_q;
  assign req_len_o   = (st_q == ST_REQ2) ? second_q : first_q;
  assign rsp_ready_o = (st_q == ST_RSP1) || (st_q == ST_RSP2);
  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = (st_q == ST_DONE);
  assign madr_o      = madr_r;
  assign avail_o     = avail_r;
  assign moved_o     = moved_r;
  assign cost_o      = cost_r;

  logic [XW-1:0] ring_end_x, burst_end_x;
  assign ring_end_x  = XW'(base_q) + XW'(mask_q) + XW'(16);
  assign burst_end_x = XW'(req_addr_o) + (XW'(req_len_o) << 4);

  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_addr_o) && $stable(req_len_o))
    else $error("request changed before acceptance");

  p_phase_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid_o && rsp_ready_o))
    else $error("request and response phases overlap");

  p_len_nonzero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |-> req_len_o != '0)
    else $error("zero-length burst requested");

  p_no_cross_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o && !lin_q |-> burst_end_x <= ring_end_x)
    else $error("ring burst crosses ring end");

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o)
    else $error("done longer than one cycle");

  p_moved_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (CW+1)'(moved_o) <= (CW+1)'(first_q) + (CW+1)'(second_q))
    else $error("moved exceeds requested");
endmodule

// File: rtl/ring_wrap_splitter.sv
module ring_wrap_splitter #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] ring_base_i,
  input  logic [AW-1:0] ring_mask_i,
  input  logic [AW-1:0] madr_i,
  input  logic [CW-1:0] qwc_i,
  input  logic [CW-1:0] avail_i,
  output logic          req_valid_o,
  input  logic          req_ready_i,
  output logic [AW-1:0] req_addr_o,
  output logic [CW-1:0] req_len_o,
  input  logic          rsp_valid_i,
  output logic          rsp_ready_o,
  input  logic [CW-1:0] rsp_cnt_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [AW-1:0] madr_o,
  output logic [CW-1:0] avail_o,
  output logic [CW-1:0] moved_o,
  output logic [CW:0]   cost_o
);
  logic          in_ring, wrap;
  logic [CW-1:0] len, first_len, second_len;

  ring_plan #(.AW(AW), .CW(CW)) u_plan (
    .base_i       (ring_base_i),
    .mask_i       (ring_mask_i),
    .madr_i       (madr_i),
    .qwc_i        (qwc_i),
    .avail_i      (avail_i),
    .in_ring_o    (in_ring),
    .wrap_o       (wrap),
    .len_o        (len),
    .first_len_o  (first_len),
    .second_len_o (second_len)
  );

  ring_seq #(.AW(AW), .CW(CW)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .in_ring_i    (in_ring),
    .wrap_i       (wrap),
    .len_i        (len),
    .first_len_i  (first_len),
    .second_len_i (second_len),
    .base_i       (ring_base_i),
    .mask_i       (ring_mask_i),
    .madr_i       (madr_i),
    .avail_i      (avail_i),
    .req_valid_o  (req_valid_o),
    .req_ready_i  (req_ready_i),
    .req_addr_o   (req_addr_o),
    .req_len_o    (req_len_o),
    .rsp_valid_i  (rsp_valid_i),
    .rsp_ready_o  (rsp_ready_o),
    .rsp_cnt_i    (rsp_cnt_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .madr_o       (madr_o),
    .avail_o      (avail_o),
    .moved_o      (moved_o),
    .cost_o       (cost_o)
  );
endmodule

// File: tb/ring_wrap_splitter_test.sv
module ring_wrap_splitter_test;
  localparam int AW = 32;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          start_i = 1'b0;
  logic [AW-1:0] ring_base_i = '0, ring_mask_i = '0, madr_i = '0;
  logic [CW-1:0] qwc_i = '0, avail_i = '0, rsp_cnt_i = '0;
  logic          req_ready_i = 1'b0, rsp_valid_i = 1'b0;
  logic          req_valid_o, rsp_ready_o, busy_o, done_o;
  logic [AW-1:0] req_addr_o, madr_o;
  logic [CW-1:0] req_len_o, avail_o, moved_o;
  logic [CW:0]   cost_o;

  ring_wrap_splitter #(.AW(AW), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .ring_base_i(ring_base_i), .ring_mask_i(ring_mask_i), .madr_i(madr_i),
    .qwc_i(qwc_i), .avail_i(avail_i),
    .req_valid_o(req_valid_o), .req_ready_i(req_ready_i),
    .req_addr_o(req_addr_o), .req_len_o(req_len_o),
    .rsp_valid_i(rsp_valid_i), .rsp_ready_o(rsp_ready_o), .rsp_cnt_i(rsp_cnt_i),
    .busy_o(busy_o), .done_o(done_o), .madr_o(madr_o), .avail_o(avail_o),
    .moved_o(moved_o), .cost_o(cost_o)
  );

  int checks = 0;
  int fails = 0;
  longint q_addr[$];
  int     q_len[$];
  int     q_cnt[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog run hung actual=0 expected=1");
    summary();
  end

  // Behavioural reference: builds the expected burst list and results, then
  // plays the ready/response side and compares on every clock.
  task automatic run(input string tag, input longint b, input longint m,
                     input longint a, input int q, input int av,
                     input bit short1, input int dly);
    longint endr = b + m + 16;
    bit inr = (a >= b) && (a <= b + m);
    int len, s1, c1, moved, eav, ecost;
    longint em;
    int guard;
    q_addr.delete(); q_len.delete(); q_cnt.delete();
    em = a;
    moved = 0;
    if (!inr) begin
      len = q;
      eav = av;
      if (len > 0) begin
        q_addr.push_back(a); q_len.push_back(len);
        c1 = short1 ? len - 1 : len;
        q_cnt.push_back(c1); moved = c1;
      end
      ecost = 2 * moved;
    end else begin
      len = (av < q) ? av : q;
      ecost = 0;
      if (len == 0) begin
        moved = 0;
      end else if (a + longint'(len) * 16 > endr) begin
        s1 = int'((endr - a) >> 4);
        q_addr.push_back(a); q_len.push_back(s1);
        c1 = short1 ? s1 - 1 : s1;
        q_cnt.push_back(c1);
        if (c1 == s1) begin
          q_addr.push_back(b); q_len.push_back(len - s1); q_cnt.push_back(len - s1);
          moved = len;
        end else moved = c1;
      end else begin
        q_addr.push_back(a); q_len.push_back(len);
        c1 = short1 ? len - 1 : len;
        q_cnt.push_back(c1); moved = c1;
        em = b + (a & m);
      end
      eav = av - moved;
    end

    ring_base_i = AW'(b); ring_mask_i = AW'(m); madr_i = AW'(a);
    qwc_i = CW'(q); avail_i = CW'(av);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R8", {tag, " busy after start"}, busy_o, 1);
    guard = 0;
    while (!done_o && guard < 200) begin
      guard++;
      if (req_valid_o) begin
        if (q_addr.size() == 0) begin
          chk(0, "R1", {tag, " unexpected request"}, req_len_o, 0);
          req_ready_i = 1'b1; @(negedge clk); req_ready_i = 1'b0;
          rsp_valid_i = 1'b1; rsp_cnt_i = req_len_o; @(negedge clk); rsp_valid_i = 1'b0;
        end else begin
          chk(longint'(req_addr_o) == q_addr[0], "R2", {tag, " burst address"}, req_addr_o, q_addr[0]);
          chk(int'(req_len_o) == q_len[0], "R2", {tag, " burst length"}, req_len_o, q_len[0]);
          for (int i = 0; i < dly; i++) begin
            start_i = 1'b1;
            madr_i = AW'(a + 'h100);
            qwc_i = CW'(q + 3);
            @(negedge clk);
            chk(req_valid_o && longint'(req_addr_o) == q_addr[0] && int'(req_len_o) == q_len[0],
                "R7", {tag, " request held while stalled"}, req_addr_o, q_addr[0]);
          end
          start_i = 1'b0;
          req_ready_i = 1'b1;
          @(negedge clk);
          req_ready_i = 1'b0;
          void'(q_addr.pop_front()); void'(q_len.pop_front());
          chk(rsp_ready_o && !req_valid_o, "R7", {tag, " response phase"}, rsp_ready_o, 1);
          rsp_valid_i = 1'b1;
          rsp_cnt_i = CW'(q_cnt.pop_front());
          @(negedge clk);
          rsp_valid_i = 1'b0;
        end
      end else begin
        @(negedge clk);
      end
    end
    chk(done_o == 1'b1, "R8", {tag, " done reached"}, done_o, 1);
    chk(q_addr.size() == 0, "R3", {tag, " bursts outstanding"}, q_addr.size(), 0);
    chk(longint'(madr_o) == em, (inr && len > 0 && em == a) ? "R9" : "R4", {tag, " pointer"}, madr_o, em);
    chk(int'(avail_o) == eav, "R5", {tag, " available"}, avail_o, eav);
    chk(int'(moved_o) == moved, "R5", {tag, " moved"}, moved_o, moved);
    chk(int'(cost_o) == ecost, "R6", {tag, " cost"}, cost_o, ecost);
    @(negedge clk);
    chk(!done_o && !busy_o, "R8", {tag, " idle after done"}, done_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!req_valid_o && !rsp_ready_o && !busy_o && !done_o, "R8", "reset outputs quiet",
        {req_valid_o, rsp_ready_o, busy_o, done_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // ring 16 quadwords at 0x1000, end 0x1100
    run("r4_nowrap",      'h1000, 'hF0, 'h1020, 4, 10, 0, 0);
    run("r1_availcap",    'h1000, 'hF0, 'h1040, 10, 3, 0, 1);
    run("r2_wrap",        'h1000, 'hF0, 'h10C0, 8, 8, 0, 0);
    run("r3_shortfirst",  'h1000, 'hF0, 'h10C0, 8, 8, 1, 0);
    run("r2_exactend",    'h1000, 'hF0, 'h10C0, 4, 9, 0, 0);
    run("r6_linear",      'h1000, 'hF0, 'h2000, 5, 2, 0, 0);
    run("r6_linshort",    'h1000, 'hF0, 'h2000, 5, 2, 1, 2);
    run("r6_justpast",    'h1000, 'hF0, 'h1100, 3, 9, 0, 0);
    run("r6_below",       'h1000, 'hF0, 'h0FF0, 2, 9, 0, 0);
    run("r1_zeroqwc",     'h1000, 'hF0, 'h1020, 0, 5, 0, 0);
    run("r1_zeroavail",   'h1000, 'hF0, 'h1020, 6, 0, 0, 0);
    run("r8_busystart",   'h1000, 'hF0, 'h10E0, 6, 6, 0, 3);
    run("r2_lastslot",    'h4000, 'h3F0, 'h43F0, 3, 40, 0, 1);
    run("r9_wrapfull",    'h4000, 'h3F0, 'h4200, 64, 64, 0, 0);
    summary();
  end
endmodule